// File: doc/BRIEF.md
# Flash Program and Erase Sequencer

This block is the embedded algorithm engine of a small emulated flash array. A command decoder hands it one of three jobs: write a single byte, wipe one sector, or wipe the whole array. The block then runs the entire job by itself. It produces self-timed program and erase pulses on a memory-array port. It reads the array back to verify each step, and it repeats a pulse when the verify fails. Before any erase, it drives every byte of the target region to the programmed value.

The array is split into sectors selected by the top address bits. With the default parameters there are 128K bytes in eight 16K-byte sectors. A programmed byte reads 0x00 and an erased byte reads 0xFF. A program pulse can only clear bits; an erase pulse sets a whole sector to 0xFF.

Once a job has been accepted, `busy` stays high until the job ends. It stays high even if the chip select falls during the job. The end is marked by a single-cycle `done` and by a `fail` level that reports the result.

Top module: `flash_seq`

## Requirements
- R1: An accepted program request (`req_op` = 2'b01) drives `busy` high from the next cycle. It applies program pulses to `req_addr` with `arr_wdata` equal to `req_data`, and verifies the byte after each pulse. When the byte reads back equal to `req_data`, the job ends with `fail` low.
- R2: Every program pulse holds `arr_pgm` high for exactly PGM_CYC consecutive cycles. Every erase pulse holds `arr_ers` high for exactly ERS_CYC consecutive cycles. The two strobes are never high together.
- R3: Before the first erase pulse on a sector, every byte of that sector reads 0x00. A byte that already reads 0x00 receives no program pulse during this pre-program phase.
- R4: After a successful erase job, every byte of each target sector reads 0xFF.
- R5: A sector erase (`req_op` = 2'b10) affects only the sector given by `req_addr[ADDR_W-1:ADDR_W-SECT_W]`, driven on `arr_sect`. All bytes of every other sector stay unchanged.
- R6: A chip erase (`req_op` = 2'b11) pre-programs and erases every sector, one at a time, in ascending sector order starting at 0.
- R7: When a verify fails, the block applies the pulse again, up to MAX_TRY pulses for one byte or one sector erase. If the last permitted pulse still fails, the job ends with `fail` high. In that case no further pulse is issued and `busy` drops.
- R8: A program request whose data has a 1 where the stored byte has a 0 cannot verify. It ends with `fail` high after exactly MAX_TRY program pulses, and the stored byte is not changed beyond the bits it could clear.
- R9: A request is accepted only while idle, with `ce` high and `req_op` not 2'b00. Requests that arrive while busy have no effect on the array. Dropping `ce` during a job does not stop it.
- R10: After reset, `busy`, `done`, `fail`, `arr_pgm` and `arr_ers` are all low.
- R11: `done` is high for exactly one cycle at the end of each job, with `busy` already low. `fail` keeps its value until the next request is accepted, which clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce | input | 1 | Chip select; gates acceptance of requests only |
| req_valid | input | 1 | Request strobe |
| req_op | input | 2 | 01 program, 10 sector erase, 11 chip erase, 00 nothing |
| req_addr | input | ADDR_W | Byte address; upper SECT_W bits choose the sector |
| req_data | input | 8 | Byte to program |
| busy | output | 1 | A job is in progress |
| done | output | 1 | One-cycle end-of-job marker |
| fail | output | 1 | Result of the last job; high on verify exhaustion |
| arr_addr | output | ADDR_W | Array byte address for program and read-back |
| arr_wdata | output | 8 | Data applied during a program pulse |
| arr_pgm | output | 1 | Program pulse strobe |
| arr_ers | output | 1 | Sector erase pulse strobe |
| arr_sect | output | SECT_W | Sector targeted by an erase pulse |
| arr_rdata | input | 8 | Array read data for `arr_addr`, valid in the same cycle |

## Verification
The hardest situation to reach from the ports is a verify that fails while the sequence itself is correct. A healthy array always accepts a pulse, so the retry and fail paths would never run. The bench's array model can be told to swallow the next N program or erase pulses, which steers the block into one, two or all of its permitted retries. A second route to the fail path needs no injection: the bench programs a byte that would require setting a bit. Each sector is swept with a mixed pattern of zero and non-zero bytes, so the count of pre-program pulses is known in advance.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

   typedef enum logic [1:0] {
      OP_NONE = 2'b00,
      OP_PROG = 2'b01,
      OP_SECT = 2'b10,
      OP_CHIP = 2'b11
   } op_e;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_P_PULSE,
      ST_P_VFY,
      ST_E_CHK,
      ST_E_PRE,
      ST_E_PVFY,
      ST_E_PULSE,
      ST_E_VFY
   } st_e;

endpackage

// File: rtl/pulse_timer.sv
module pulse_timer #(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             zero
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign zero = (cnt_q == '0);

endmodule

// File: rtl/addr_walker.sv
module addr_walker #(
   parameter int OFF_W = 14
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             step,
   output logic [OFF_W-1:0] off,
   output logic             last
);
   logic [OFF_W-1:0] off_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         off_q <= '0;
      end else if (clr) begin
         off_q <= '0;
      end else if (step) begin
         off_q <= off_q + 1'b1;
      end
   end

   assign off  = off_q;
   assign last = &off_q;

endmodule

// File: rtl/byte_match.sv
module byte_match #(
   parameter bit ERASED = 1'b1
) (
   input  logic [7:0] rd,
   output logic       hit
);
   generate
      if (ERASED) begin : g_erased
         assign hit = (rd == 8'hFF);
      end else begin : g_programmed
         assign hit = (rd == 8'h00);
      end
   endgenerate

endmodule

// File: rtl/flash_seq.sv
module flash_seq
   import flash_seq_pkg::*;
#(
   parameter int ADDR_W  = 17,
   parameter int SECT_W  = 3,
   parameter int PGM_CYC = 40,
   parameter int ERS_CYC = 400,
   parameter int MAX_TRY = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce,
   input  logic              req_valid,
   input  logic [1:0]        req_op,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [7:0]        req_data,
   output logic              busy,
   output logic              done,
   output logic              fail,
   output logic [ADDR_W-1:0] arr_addr,
   output logic [7:0]        arr_wdata,
   output logic              arr_pgm,
   output logic              arr_ers,
   output logic [SECT_W-1:0] arr_sect,
   input  logic [7:0]        arr_rdata
);
   localparam int OFF_W = ADDR_W - SECT_W;
   localparam int MAXC  = (PGM_CYC > ERS_CYC) ? PGM_CYC : ERS_CYC;
   localparam int TMR_W = $clog2(MAXC + 1);
   localparam int TRY_W = $clog2(MAX_TRY + 1);
   localparam logic [TMR_W-1:0] PGM_V = TMR_W'(PGM_CYC - 1);
   localparam logic [TMR_W-1:0] ERS_V = TMR_W'(ERS_CYC - 1);
   localparam logic [TRY_W-1:0] TRY_LIM = TRY_W'(MAX_TRY);

   // elaboration-time parameter checks
   generate
      if (SECT_W < 1 || OFF_W < 1) begin : g_bad_split
         $error("flash_seq: ADDR_W must exceed SECT_W and SECT_W must be positive");
      end
      if (PGM_CYC < 1 || ERS_CYC < 1) begin : g_bad_pulse
         $error("flash_seq: pulse widths must be at least one cycle");
      end
      if (MAX_TRY < 1) begin : g_bad_try
         $error("flash_seq: MAX_TRY must be at least one");
      end
   endgenerate

   st_e               st_q;
   op_e               op_q;
   logic [ADDR_W-1:0] pa_q;
   logic [7:0]        pd_q;
   logic [SECT_W-1:0] sec_q, sec_last_q;
   logic [TRY_W-1:0]  tries_q;
   logic [TRY_W-1:0]  tries_nx;
   logic              done_q, fail_q;

   logic              accept;
   logic              hit_zero, hit_ff, hit_prog;
   logic              exhaust;
   logic              in_pulse;
   logic              tmr_zero;
   logic [TMR_W-1:0]  tmr_val;
   logic              wk_clr, wk_step, off_last;
   logic [OFF_W-1:0]  off;
   logic              pre_item_ok;

   assign accept   = (st_q == ST_IDLE) && req_valid && ce && (op_e'(req_op) != OP_NONE);
   assign hit_prog = (arr_rdata == pd_q);
   assign tries_nx = tries_q + 1'b1;
   assign exhaust  = (tries_nx >= TRY_LIM);
   assign in_pulse = (st_q == ST_P_PULSE) || (st_q == ST_E_PRE) || (st_q == ST_E_PULSE);
   assign pre_item_ok = ((st_q == ST_E_CHK) || (st_q == ST_E_PVFY)) && hit_zero;

   byte_match #(.ERASED(1'b0)) u_match_zero (.rd(arr_rdata), .hit(hit_zero));
   byte_match #(.ERASED(1'b1)) u_match_ff   (.rd(arr_rdata), .hit(hit_ff));

   // timer loads whenever no pulse runs; value picked for the pulse that follows
   assign tmr_val = ((st_q == ST_E_VFY) || (pre_item_ok && off_last)) ? ERS_V : PGM_V;

   pulse_timer #(.CNT_W(TMR_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (!in_pulse),
      .load_val (tmr_val),
      .zero     (tmr_zero)
   );

   assign wk_clr  = accept || (st_q == ST_E_PULSE) || ((st_q == ST_E_VFY) && hit_ff && off_last);
   assign wk_step = (pre_item_ok && !off_last) || ((st_q == ST_E_VFY) && hit_ff && !off_last);

   addr_walker #(.OFF_W(OFF_W)) u_walker (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (wk_clr),
      .step  (wk_step),
      .off   (off),
      .last  (off_last)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= ST_IDLE;
         op_q       <= OP_NONE;
         pa_q       <= '0;
         pd_q       <= '0;
         sec_q      <= '0;
         sec_last_q <= '0;
         tries_q    <= '0;
         done_q     <= 1'b0;
         fail_q     <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (st_q)
            ST_IDLE: begin
               if (accept) begin
                  op_q    <= op_e'(req_op);
                  pa_q    <= req_addr;
                  pd_q    <= req_data;
                  tries_q <= '0;
                  fail_q  <= 1'b0;
                  if (op_e'(req_op) == OP_PROG) begin
                     st_q <= ST_P_PULSE;
                  end else begin
                     st_q <= ST_E_CHK;
                     if (op_e'(req_op) == OP_CHIP) begin
                        sec_q      <= '0;
                        sec_last_q <= '1;
                     end else begin
                        sec_q      <= req_addr[ADDR_W-1:OFF_W];
                        sec_last_q <= req_addr[ADDR_W-1:OFF_W];
                     end
                  end
               end
            end
            ST_P_PULSE: begin
               if (tmr_zero) st_q <= ST_P_VFY;
            end
            ST_P_VFY: begin
               if (hit_prog || exhaust) begin
                  st_q   <= ST_IDLE;
                  done_q <= 1'b1;
                  fail_q <= !hit_prog;
               end else begin
                  tries_q <= tries_nx;
                  st_q    <= ST_P_PULSE;
               end
            end
            ST_E_CHK: begin
               tries_q <= '0;
               if (!hit_zero)     st_q <= ST_E_PRE;
               else if (off_last) st_q <= ST_E_PULSE;
            end
            ST_E_PRE: begin
               if (tmr_zero) st_q <= ST_E_PVFY;
            end
            ST_E_PVFY: begin
               if (hit_zero) begin
                  tries_q <= '0;
                  st_q    <= off_last ? ST_E_PULSE : ST_E_CHK;
               end else if (exhaust) begin
                  st_q   <= ST_IDLE;
                  done_q <= 1'b1;
                  fail_q <= 1'b1;
               end else begin
                  tries_q <= tries_nx;
                  st_q    <= ST_E_PRE;
               end
            end
            ST_E_PULSE: begin
               if (tmr_zero) st_q <= ST_E_VFY;
            end
            ST_E_VFY: begin
               if (hit_ff) begin
                  if (off_last) begin
                     tries_q <= '0;
                     if (sec_q == sec_last_q) begin
                        st_q   <= ST_IDLE;
                        done_q <= 1'b1;
                        fail_q <= 1'b0;
                     end else begin
                        sec_q <= sec_q + 1'b1;
                        st_q  <= ST_E_CHK;
                     end
                  end
               end else if (exhaust) begin
                  st_q   <= ST_IDLE;
                  done_q <= 1'b1;
                  fail_q <= 1'b1;
               end else begin
                  tries_q <= tries_nx;
                  st_q    <= ST_E_PULSE;
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign busy      = (st_q != ST_IDLE);
   assign done      = done_q;
   assign fail      = fail_q;
   assign arr_addr  = (op_q == OP_PROG) ? pa_q : {sec_q, off};
   assign arr_wdata = (st_q == ST_P_PULSE) ? pd_q : 8'h00;
   assign arr_pgm   = (st_q == ST_P_PULSE) || (st_q == ST_E_PRE);
   assign arr_ers   = (st_q == ST_E_PULSE);
   assign arr_sect  = sec_q;

   // run-length counters used only by the pulse-width properties
   logic [TMR_W-1:0] pgm_run_q, ers_run_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pgm_run_q <= '0;
         ers_run_q <= '0;
      end else begin
         pgm_run_q <= arr_pgm ? pgm_run_q + 1'b1 : '0;
         ers_run_q <= arr_ers ? ers_run_q + 1'b1 : '0;
      end
   end

   AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(arr_pgm && arr_ers)); // R2
   AST_PGM_WIDTH: assert property (@(posedge clk) disable iff (!rst_n) $fell(arr_pgm) |-> (pgm_run_q == TMR_W'(PGM_CYC))); // R2
   AST_ERS_WIDTH: assert property (@(posedge clk) disable iff (!rst_n) $fell(arr_ers) |-> (ers_run_q == TMR_W'(ERS_CYC))); // R2
   AST_JOB_FROZEN: assert property (@(posedge clk) disable iff (!rst_n) busy |=> ($stable(pa_q) && $stable(pd_q) && $stable(sec_last_q))); // R9
   AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy); // R11
   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R11
   AST_SECT_ASCEND: assert property (@(posedge clk) disable iff (!rst_n) (busy && $past(busy) && (sec_q != $past(sec_q))) |-> (sec_q == SECT_W'($past(sec_q) + 1'b1))); // R6
   AST_ERS_RANGE: assert property (@(posedge clk) disable iff (!rst_n) arr_ers |-> (arr_sect <= sec_last_q)); // R5
   AST_TRY_CAP: assert property (@(posedge clk) disable iff (!rst_n) tries_q < TRY_LIM); // R7

endmodule

// File: tb/flash_seq_tb.sv
`timescale 1ns/1ps
module flash_seq_tb;
   localparam int AW = 10, SW = 3, OW = AW - SW;
   localparam int PGM = 3, ERS = 5, TRY = 3;
   localparam int NB = 1 << AW, SB = 1 << OW, NS = 1 << SW;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic          rst_n, ce, req_valid;
   logic [1:0]    req_op;
   logic [AW-1:0] req_addr;
   logic [7:0]    req_data;
   logic          busy, done, fail;
   logic [AW-1:0] arr_addr;
   logic [7:0]    arr_wdata;
   logic          arr_pgm, arr_ers;
   logic [SW-1:0] arr_sect;
   logic [7:0]    arr_rdata;

   flash_seq #(.ADDR_W(AW), .SECT_W(SW), .PGM_CYC(PGM), .ERS_CYC(ERS), .MAX_TRY(TRY)) u_dut (
      .clk(clk), .rst_n(rst_n), .ce(ce), .req_valid(req_valid), .req_op(req_op),
      .req_addr(req_addr), .req_data(req_data), .busy(busy), .done(done), .fail(fail),
      .arr_addr(arr_addr), .arr_wdata(arr_wdata), .arr_pgm(arr_pgm), .arr_ers(arr_ers),
      .arr_sect(arr_sect), .arr_rdata(arr_rdata)
   );

   // array model
   logic [7:0] mem [NB];
   assign arr_rdata = mem[arr_addr];

   int checks = 0, errors = 0;
   int pgm_cnt, ers_cnt, pgm_rej, ers_rej, wid_err, pre_err, ers_idx;
   int ers_order [16];
   int pgm_run = 0, ers_run = 0;
   logic pgm_prev = 1'b0, ers_prev = 1'b0;

   always @(posedge clk) begin
      if (arr_pgm && !pgm_prev) begin
         pgm_cnt++;
         if (pgm_rej > 0) pgm_rej--;
         else mem[arr_addr] <= mem[arr_addr] & arr_wdata;
      end
      if (arr_ers && !ers_prev) begin
         for (int i = 0; i < SB; i++)
            if (mem[int'(arr_sect) * SB + i] != 8'h00) pre_err++;
         if (ers_idx < 16) ers_order[ers_idx] = int'(arr_sect);
         ers_idx++;
         ers_cnt++;
         if (ers_rej > 0) ers_rej--;
         else for (int i = 0; i < SB; i++) mem[int'(arr_sect) * SB + i] <= 8'hFF;
      end
      if (arr_pgm) pgm_run++;
      else begin
         if (pgm_prev && pgm_run != PGM) wid_err++;
         pgm_run = 0;
      end
      if (arr_ers) ers_run++;
      else begin
         if (ers_prev && ers_run != ERS) wid_err++;
         ers_run = 0;
      end
      pgm_prev <= arr_pgm;
      ers_prev <= arr_ers;
   end

   function automatic logic [7:0] pat(int a);
      if (a % 3 == 0) return 8'h00;
      return 8'((a * 5 + 1) | 1);
   endfunction

   task automatic chk(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic clr_stats();
      pgm_cnt = 0; ers_cnt = 0; wid_err = 0; pre_err = 0; ers_idx = 0;
   endtask

   task automatic fill_ff();
      for (int i = 0; i < NB; i++) mem[i] <= 8'hFF;
   endtask

   task automatic fill_pat();
      for (int i = 0; i < NB; i++) mem[i] <= pat(i);
   endtask

   task automatic start_op(logic [1:0] op, int a, logic [7:0] d);
      @(negedge clk);
      req_valid = 1'b1; req_op = op; req_addr = AW'(a); req_data = d;
      @(negedge clk);
      req_valid = 1'b0; req_op = 2'b00;
      chk("R1 busy after accept", int'(busy), 1);
      chk("R11 fail cleared on accept", int'(fail), 0);
   endtask

   task automatic wait_done();
      int cyc = 0;
      while (!done && cyc < 40000) begin
         @(negedge clk);
         cyc++;
      end
      chk("R11 done seen", int'(done), 1);
      chk("R11 busy low at done", int'(busy), 0);
      @(negedge clk);
      chk("R11 done one cycle", int'(done), 0);
   endtask

   int sect_bad, other_bad, expect_p;

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      rst_n = 1'b0; ce = 1'b1; req_valid = 1'b0; req_op = 2'b00; req_addr = '0; req_data = '0;
      pgm_rej = 0; ers_rej = 0;
      clr_stats();
      fill_ff();
      repeat (3) @(negedge clk);
      chk("R10 busy", int'(busy), 0);
      chk("R10 done", int'(done), 0);
      chk("R10 fail", int'(fail), 0);
      chk("R10 pgm", int'(arr_pgm), 0);
      chk("R10 ers", int'(arr_ers), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 R2: program sweep
      for (int k = 0; k < 16; k++) begin
         int a = (k * 71 + 5) % NB;
         logic [7:0] d = 8'(k * 17) ^ 8'h3C;
         clr_stats();
         start_op(2'b01, a, d);
         wait_done();
         chk("R1 fail low", int'(fail), 0);
         chk("R1 byte value", int'(mem[a]), int'(d));
         chk("R1 one pulse", pgm_cnt, 1);
         chk("R2 pulse width", wid_err, 0);
      end

      // R8: clearing allowed, setting impossible
      mem[40] <= 8'h0F;
      clr_stats();
      start_op(2'b01, 40, 8'h05);
      wait_done();
      chk("R8 clear bits ok", int'(fail), 0);
      chk("R8 clear bits value", int'(mem[40]), 8'h05);
      clr_stats();
      start_op(2'b01, 40, 8'h0F);
      wait_done();
      chk("R8 set bit fails", int'(fail), 1);
      chk("R8 pulse count", pgm_cnt, TRY);
      chk("R8 byte kept", int'(mem[40]), 8'h05);

      // R7: program retries
      mem[77] <= 8'hFF;
      clr_stats(); pgm_rej = TRY - 1;
      start_op(2'b01, 77, 8'hA5);
      wait_done();
      chk("R7 late success fail", int'(fail), 0);
      chk("R7 late success pulses", pgm_cnt, TRY);
      chk("R7 late success value", int'(mem[77]), 8'hA5);
      mem[78] <= 8'hFF;
      clr_stats(); pgm_rej = TRY;
      start_op(2'b01, 78, 8'h12);
      wait_done();
      chk("R7 exhaust fail", int'(fail), 1);
      chk("R7 exhaust pulses", pgm_cnt, TRY);
      chk("R7 exhaust value", int'(mem[78]), 8'hFF);
      repeat (5) @(negedge clk);
      chk("R11 fail holds", int'(fail), 1);
      clr_stats();
      start_op(2'b01, 79, 8'hFF);
      wait_done();
      chk("R11 fail after good job", int'(fail), 0);

      // R3 R4 R5: each sector alone
      for (int s = 0; s < NS; s++) begin
         fill_pat();
         clr_stats();
         expect_p = 0;
         for (int i = 0; i < SB; i++) if (pat(s * SB + i) != 8'h00) expect_p++;
         start_op(2'b10, s * SB + (s * 13) % SB, 8'h00);
         wait_done();
         sect_bad = 0; other_bad = 0;
         for (int i = 0; i < NB; i++) begin
            if (i / SB == s) begin if (mem[i] != 8'hFF) sect_bad++; end
            else if (mem[i] != pat(i)) other_bad++;
         end
         chk("R4 sector erase ok", int'(fail), 0);
         chk("R3 pre-program pulses", pgm_cnt, expect_p);
         chk("R3 zeroed before erase", pre_err, 0);
         chk("R4 sector all FF", sect_bad, 0);
         chk("R5 other sectors kept", other_bad, 0);
         chk("R5 erased sector index", ers_order[0], s);
         chk("R2 widths", wid_err, 0);
      end

      // R7: erase retries
      fill_pat(); clr_stats(); ers_rej = 1;
      start_op(2'b10, 2 * SB, 8'h00);
      wait_done();
      chk("R7 erase retry ok", int'(fail), 0);
      chk("R7 erase pulses", ers_cnt, 2);
      sect_bad = 0;
      for (int i = 0; i < SB; i++) if (mem[2 * SB + i] != 8'hFF) sect_bad++;
      chk("R7 erase retry FF", sect_bad, 0);
      clr_stats(); ers_rej = TRY;
      start_op(2'b10, 3 * SB, 8'h00);
      wait_done();
      chk("R7 erase exhaust", int'(fail), 1);
      chk("R7 erase exhaust pulses", ers_cnt, TRY);

      // R6: chip erase in ascending order
      fill_pat(); clr_stats();
      expect_p = 0;
      for (int i = 0; i < NB; i++) if (pat(i) != 8'h00) expect_p++;
      start_op(2'b11, 5, 8'h00);
      wait_done();
      chk("R6 chip ok", int'(fail), 0);
      chk("R6 erase count", ers_cnt, NS);
      other_bad = 0;
      for (int s = 0; s < NS; s++) if (ers_order[s] != s) other_bad++;
      chk("R6 ascending order", other_bad, 0);
      sect_bad = 0;
      for (int i = 0; i < NB; i++) if (mem[i] != 8'hFF) sect_bad++;
      chk("R4 chip all FF", sect_bad, 0);
      chk("R3 chip pre-program pulses", pgm_cnt, expect_p);

      // R9: requests during a job, and ce dropped mid-job
      fill_pat(); clr_stats();
      expect_p = 0;
      for (int i = 0; i < SB; i++) if (pat(SB + i) != 8'h00) expect_p++;
      start_op(2'b10, SB + 3, 8'h00);
      req_valid = 1'b1; req_op = 2'b01; req_addr = AW'(5 * SB + 1); req_data = 8'h00;
      @(negedge clk);
      req_op = 2'b11;
      @(negedge clk);
      req_valid = 1'b0; req_op = 2'b00; ce = 1'b0;
      wait_done();
      ce = 1'b1;
      other_bad = 0;
      for (int i = 0; i < NB; i++) if (i / SB != 1 && mem[i] != pat(i)) other_bad++;
      chk("R9 busy requests ignored", other_bad, 0);
      chk("R9 only own pulses", pgm_cnt, expect_p);
      chk("R9 one erase pulse", ers_cnt, 1);
      chk("R9 job finished with ce low", int'(fail), 0);

      // R9: idle requests that must not start
      clr_stats();
      @(negedge clk);
      ce = 1'b0; req_valid = 1'b1; req_op = 2'b01; req_addr = AW'(1); req_data = 8'h00;
      @(negedge clk);
      req_valid = 1'b0; ce = 1'b1;
      @(negedge clk);
      chk("R9 ce low no start", int'(busy), 0);
      req_valid = 1'b1; req_op = 2'b00;
      @(negedge clk);
      req_valid = 1'b0;
      @(negedge clk);
      chk("R9 op none no start", int'(busy), 0);
      chk("R9 no pulses", pgm_cnt, 0);
      chk("R9 byte unchanged", int'(mem[1]), int'(pat(1)));

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule